// File: doc/BRIEF.md
# Loop Closure Detector

This block decides whether the subscriber loop has gone off-hook. A monitor converter delivers one loop current sample and one loop voltage sample per strobe, at about 800 Hz, each as a sign bit over a 6-bit magnitude. The detector accepts a sample only while the line is driven in one of its powered, non-ringing feed states. It smooths the selected quantity with a first-order low-pass filter and compares the filtered magnitude against programmable levels. It then debounces the comparison over a programmable number of samples before the loop closure status is allowed to move.

Two detection senses are available. In current mode the loop counts as closed when enough current flows. In voltage mode it counts as closed when the loop voltage sags below a minimum. Either sense can use a single level or a pair of levels forming a hysteresis band. Every debounced transition can raise a sticky interrupt-pending flag, which software clears with a one-cycle clear pulse.

Top module: `loop_close_det`

## Requirements
- R1: After reset, `hook_closed` and `irq_pend` are both 0.
- R2: A sample word carries the sign in bit 6 and the magnitude in bits 5:0. Detection uses the magnitude of the filtered value, so a negative current of a given size closes the loop just as a positive one does.
- R3: A strobe is accepted only when `feed_state` is 3'b001, 3'b010, 3'b101 or 3'b110. In any other state the strobe is ignored: the filter, the debounce count, `hook_closed` and `irq_pend` keep their values.
- R4: Each accepted sample updates the filter as y = y + (x - y)·(lpf_coef + 1)/4096, with 12 fractional bits kept. With `lpf_coef` = 4095 the filter follows the input exactly.
- R5: In current mode (`vmode` = 0) without hysteresis, the comparator reports closed when the filtered magnitude is strictly greater than `thr_hi`.
- R6: In current mode with `hyst_en` = 1, the comparator closes when the magnitude exceeds `thr_hi`. Once closed, it releases only when the magnitude is at or below `thr_lo`.
- R7: In voltage mode (`vmode` = 1) the voltage sample is filtered instead. Without hysteresis the comparator reports closed when the magnitude is below `thr_hi`. With hysteresis it closes when the magnitude is below `thr_lo` and releases when it is above `thr_hi`.
- R8: `hook_closed` flips only after `dbc_ticks` consecutive accepted samples disagree with it, with 0 treated as 1. Any accepted sample that agrees with it restarts the count.
- R9: When the strobe is captured on clock edge N, the resulting change of `hook_closed` appears at edge N+1.
- R10: Every flip of `hook_closed`, closing or releasing, sets `irq_pend` when `irq_en` is 1. When `irq_en` is 0, a flip leaves `irq_pend` at 0.
- R11: A one-cycle `irq_clr` pulse clears `irq_pend`. If a flip with `irq_en` = 1 lands on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle strobe marking a new sample pair |
| cur_smp | input | 7 | Loop current sample, sign bit 6, magnitude 5:0 |
| volt_smp | input | 7 | Loop voltage sample, sign bit 6, magnitude 5:0 |
| feed_state | input | 3 | Present linefeed state code |
| thr_hi | input | 6 | Upper threshold |
| thr_lo | input | 6 | Lower threshold, used with hysteresis |
| hyst_en | input | 1 | Enables the two-level hysteresis band |
| vmode | input | 1 | 0 selects current sensing, 1 selects voltage sensing |
| lpf_coef | input | 12 | Filter coefficient k, gain (k+1)/4096 |
| dbc_ticks | input | 8 | Debounce interval in accepted samples |
| irq_en | input | 1 | Allows debounced transitions to set the interrupt flag |
| irq_clr | input | 1 | Write-one-to-clear pulse for the interrupt flag |
| hook_closed | output | 1 | Debounced loop closure status |
| irq_pend | output | 1 | Sticky interrupt-pending flag |

## Verification
The bench drives a threshold-equal sample to catch a design that uses a non-strict comparison, which would close one step early. It interleaves an agreeing sample inside a run of disagreeing ones to expose a debounce counter that pauses instead of restarting. It feeds strobes in open and ringing states and then a filtered step. A design that let gated samples reach the filter would close on the first accepted sample instead of the third. It also lands a clear pulse on the same edge as a release, to catch a design that lets the clear win and loses the release interrupt.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    typedef enum logic [2:0] {
        FEED_OPEN      = 3'b000,
        FEED_FWD_ACT   = 3'b001,
        FEED_FWD_XMIT  = 3'b010,
        FEED_TIP_FLOAT = 3'b011,
        FEED_RINGING   = 3'b100,
        FEED_REV_ACT   = 3'b101,
        FEED_REV_XMIT  = 3'b110,
        FEED_RING_FLOAT= 3'b111
    } feed_state_e;

    // R3: detection runs only in the four powered, non-ringing feed states
    function automatic logic feed_is_sensing(input logic [2:0] code);
        feed_is_sensing = (code == FEED_FWD_ACT)  || (code == FEED_FWD_XMIT) ||
                          (code == FEED_REV_ACT)  || (code == FEED_REV_XMIT);
    endfunction

    typedef enum logic {
        SENSE_CURRENT = 1'b0,
        SENSE_VOLTAGE = 1'b1
    } sense_mode_e;

endpackage

// File: rtl/lcd_front.sv
module lcd_front #(
    parameter int MAG_W = 6
) (
    input  logic                    smp_stb,
    input  logic [2:0]              feed_state,
    input  logic                    vmode,
    input  logic [MAG_W:0]          cur_smp,
    input  logic [MAG_W:0]          volt_smp,
    output logic                    accept,
    output logic signed [MAG_W:0]   x_val
);
    import lcd_pkg::*;

    localparam int N_CH = 2;

    logic signed [MAG_W:0] conv [N_CH];
    logic [MAG_W:0]        raw  [N_CH];

    assign raw[0] = cur_smp;
    assign raw[1] = volt_smp;

    // R2: sign-magnitude to two's complement, one converter per channel
    for (genvar g = 0; g < N_CH; g++) begin : g_conv
        logic signed [MAG_W:0] pos_v;
        always_comb begin
            pos_v = $signed({1'b0, raw[g][MAG_W-1:0]});
            if (raw[g][MAG_W]) begin
                conv[g] = -pos_v;
            end else begin
                conv[g] = pos_v;
            end
        end
    end

    always_comb begin
        accept = smp_stb && feed_is_sensing(feed_state);
        if (sense_mode_e'(vmode) == SENSE_VOLTAGE) begin
            x_val = conv[1];
        end else begin
            x_val = conv[0];
        end
    end

endmodule

// File: rtl/lcd_lpf.sv
module lcd_lpf #(
    parameter int MAG_W  = 6,
    parameter int COEF_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd,
    input  logic signed [MAG_W:0]   x_in,
    input  logic [COEF_W-1:0]       coef,
    output logic [MAG_W-1:0]        mag_out
);
    localparam int ACC_W  = MAG_W + 1 + COEF_W;
    localparam int GAIN_W = COEF_W + 2;
    localparam int PROD_W = ACC_W + 1 + GAIN_W;

    typedef struct packed {
        logic signed [ACC_W-1:0] y;
    } lpf_state_t;

    lpf_state_t st_d, st_q;

    logic signed [ACC_W:0]    x_wide;
    logic signed [ACC_W:0]    diff;
    logic signed [GAIN_W-1:0] gain;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] step;
    logic signed [ACC_W-1:0]  y_abs;

    always_comb begin
        st_d   = st_q;
        x_wide = (ACC_W+1)'(x_in) <<< COEF_W;
        diff   = x_wide - (ACC_W+1)'(st_q.y);
        gain   = $signed({2'b00, coef} + {{(GAIN_W-1){1'b0}}, 1'b1});
        prod   = PROD_W'(diff) * PROD_W'(gain);
        step   = prod >>> COEF_W;
        if (upd) begin
            st_d.y = st_q.y + ACC_W'(step);
        end
        if (st_q.y[ACC_W-1]) begin
            y_abs = -st_q.y;
        end else begin
            y_abs = st_q.y;
        end
        mag_out = MAG_W'(y_abs >> COEF_W);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_LPF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(st_q.y)); // R3

    AST_LPF_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && coef == '1) |=> (st_q.y == (ACC_W'($past(x_in)) <<< COEF_W))); // R4

endmodule

// File: rtl/lcd_cmp.sv
module lcd_cmp #(
    parameter int MAG_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [MAG_W-1:0]  mag,
    input  logic              vmode,
    input  logic              hyst_en,
    input  logic [MAG_W-1:0]  thr_hi,
    input  logic [MAG_W-1:0]  thr_lo,
    output logic              level
);
    import lcd_pkg::*;

    typedef struct packed {
        logic closed;
    } cmp_state_t;

    cmp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sense_mode_e'(vmode) == SENSE_CURRENT) begin
            // R5 / R6: more current than the level means closed
            if (hyst_en && st_q.closed) begin
                level = mag > thr_lo;
            end else begin
                level = mag > thr_hi;
            end
        end else begin
            // R7: less voltage than the level means closed
            if (!hyst_en) begin
                level = mag < thr_hi;
            end else if (st_q.closed) begin
                level = !(mag > thr_hi);
            end else begin
                level = mag < thr_lo;
            end
        end
        if (upd) begin
            st_d.closed = level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(st_q.closed)); // R3

endmodule

// File: rtl/lcd_debounce.sv
module lcd_debounce #(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic              level,
    input  logic [CNT_W-1:0]  interval,
    input  logic              irq_en,
    input  logic              irq_clr,
    output logic              status,
    output logic              irq_pend
);
    typedef struct packed {
        logic             status;
        logic             irq;
        logic [CNT_W-1:0] cnt;
    } dbc_state_t;

    dbc_state_t st_d, st_q;

    logic [CNT_W:0] limit;
    logic [CNT_W:0] cnt_inc;
    logic           flip;

    always_comb begin
        st_d    = st_q;
        flip    = 1'b0;
        limit   = (interval == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, interval};
        cnt_inc = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        if (upd) begin
            if (level != st_q.status) begin
                if (cnt_inc >= limit) begin
                    flip        = 1'b1;
                    st_d.status = level;
                    st_d.cnt    = '0;
                end else begin
                    st_d.cnt    = CNT_W'(cnt_inc);
                end
            end else begin
                st_d.cnt = '0;
            end
        end
        if (irq_clr) begin
            st_d.irq = 1'b0;
        end
        if (flip && irq_en) begin
            st_d.irq = 1'b1;
        end
        status   = st_q.status;
        irq_pend = st_q.irq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(st_q.status)); // R3

    AST_AGREE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && level == st_q.status) |=> (st_q.cnt == '0)); // R8

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && !st_q.irq) |=> !st_q.irq); // R10

    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !upd) |=> !st_q.irq); // R11

endmodule

// File: rtl/loop_close_det.sv
module loop_close_det #(
    parameter int MAG_W  = 6,
    parameter int COEF_W = 12,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_stb,
    input  logic [MAG_W:0]    cur_smp,
    input  logic [MAG_W:0]    volt_smp,
    input  logic [2:0]        feed_state,
    input  logic [MAG_W-1:0]  thr_hi,
    input  logic [MAG_W-1:0]  thr_lo,
    input  logic              hyst_en,
    input  logic              vmode,
    input  logic [COEF_W-1:0] lpf_coef,
    input  logic [CNT_W-1:0]  dbc_ticks,
    input  logic              irq_en,
    input  logic              irq_clr,
    output logic              hook_closed,
    output logic              irq_pend
);
    typedef struct packed {
        logic stage2;
    } top_state_t;

    top_state_t st_d, st_q;

    logic                  accept;
    logic signed [MAG_W:0] x_val;
    logic [MAG_W-1:0]      filt_mag;
    logic                  cmp_level;

    lcd_front #(.MAG_W(MAG_W)) u_front (
        .smp_stb    (smp_stb),
        .feed_state (feed_state),
        .vmode      (vmode),
        .cur_smp    (cur_smp),
        .volt_smp   (volt_smp),
        .accept     (accept),
        .x_val      (x_val)
    );

    lcd_lpf #(.MAG_W(MAG_W), .COEF_W(COEF_W)) u_lpf (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (accept),
        .x_in    (x_val),
        .coef    (lpf_coef),
        .mag_out (filt_mag)
    );

    always_comb begin
        st_d        = st_q;
        st_d.stage2 = accept;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    lcd_cmp #(.MAG_W(MAG_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (st_q.stage2),
        .mag     (filt_mag),
        .vmode   (vmode),
        .hyst_en (hyst_en),
        .thr_hi  (thr_hi),
        .thr_lo  (thr_lo),
        .level   (cmp_level)
    );

    lcd_debounce #(.CNT_W(CNT_W)) u_dbc (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (st_q.stage2),
        .level    (cmp_level),
        .interval (dbc_ticks),
        .irq_en   (irq_en),
        .irq_clr  (irq_clr),
        .status   (hook_closed),
        .irq_pend (irq_pend)
    );

    AST_GATED_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && !lcd_pkg::feed_is_sensing(feed_state)) |=> !st_q.stage2); // R3

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.stage2 |=> $stable(hook_closed)); // R9

endmodule

// File: tb/loop_close_det_tb.sv
module loop_close_det_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_stb = 1'b0;
    logic [6:0]  cur_smp = '0;
    logic [6:0]  volt_smp = '0;
    logic [2:0]  feed_state = 3'b001;
    logic [5:0]  thr_hi = '0;
    logic [5:0]  thr_lo = '0;
    logic        hyst_en = 1'b0;
    logic        vmode = 1'b0;
    logic [11:0] lpf_coef = 12'hFFF;
    logic [7:0]  dbc_ticks = 8'd1;
    logic        irq_en = 1'b0;
    logic        irq_clr = 1'b0;
    logic        hook_closed;
    logic        irq_pend;

    int tests_run = 0;
    int tests_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    loop_close_det u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_stb     (smp_stb),
        .cur_smp     (cur_smp),
        .volt_smp    (volt_smp),
        .feed_state  (feed_state),
        .thr_hi      (thr_hi),
        .thr_lo      (thr_lo),
        .hyst_en     (hyst_en),
        .vmode       (vmode),
        .lpf_coef    (lpf_coef),
        .dbc_ticks   (dbc_ticks),
        .irq_en      (irq_en),
        .irq_clr     (irq_clr),
        .hook_closed (hook_closed),
        .irq_pend    (irq_pend)
    );

    function automatic logic [6:0] sm(input logic neg, input int m);
        return {neg, 6'(m)};
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        tests_run++;
        if (act !== exp) begin
            tests_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n      = 1'b0;
        smp_stb    = 1'b0;
        irq_clr    = 1'b0;
        feed_state = 3'b001;
        hyst_en    = 1'b0;
        vmode      = 1'b0;
        lpf_coef   = 12'hFFF;
        dbc_ticks  = 8'd1;
        irq_en     = 1'b0;
        cur_smp    = '0;
        volt_smp   = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // strobe one sample pair; returns at the negedge after the status update edge
    task automatic push(input logic [6:0] c, input logic [6:0] v);
        @(negedge clk);
        cur_smp  = c;
        volt_smp = v;
        smp_stb  = 1'b1;
        @(negedge clk);
        smp_stb  = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "status after reset", hook_closed, 1'b0);
        check("R1", "irq after reset", irq_pend, 1'b0);
    endtask

    task automatic t_gating_latency();
        do_reset();
        thr_hi = 6'd20;
        irq_en = 1'b1;
        feed_state = 3'b000;
        push(sm(0, 40), '0);
        check("R3", "open state ignored", hook_closed, 1'b0);
        feed_state = 3'b100;
        push(sm(0, 40), '0);
        check("R3", "ringing state ignored", hook_closed, 1'b0);
        check("R3", "no irq while gated", irq_pend, 1'b0);
        feed_state = 3'b110;
        @(negedge clk);
        cur_smp = sm(0, 40);
        smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
        check("R9", "status not yet moved one edge after strobe", hook_closed, 1'b0);
        @(negedge clk);
        check("R9", "status moved on following edge", hook_closed, 1'b1);
        check("R3", "reverse transmit state accepted", hook_closed, 1'b1);
    endtask

    task automatic t_threshold_edge();
        do_reset();
        thr_hi = 6'd20;
        feed_state = 3'b010;
        push(sm(0, 20), '0);
        check("R5", "equal to upper level stays open", hook_closed, 1'b0);
        push(sm(0, 21), '0);
        check("R5", "above upper level closes", hook_closed, 1'b1);
        push(sm(0, 15), '0);
        check("R5", "no hysteresis releases at 15", hook_closed, 1'b0);
    endtask

    task automatic t_negative();
        do_reset();
        thr_hi = 6'd20;
        feed_state = 3'b101;
        push(sm(1, 40), '0);
        check("R2", "negative current closes", hook_closed, 1'b1);
        push(sm(1, 0), '0);
        check("R2", "negative zero releases", hook_closed, 1'b0);
    endtask

    task automatic t_debounce_irq();
        do_reset();
        thr_hi = 6'd20;
        dbc_ticks = 8'd3;
        irq_en = 1'b1;
        push(sm(0, 40), '0);
        push(sm(0, 40), '0);
        check("R8", "two of three disagreeing", hook_closed, 1'b0);
        push(sm(0, 10), '0);
        push(sm(0, 40), '0);
        push(sm(0, 40), '0);
        check("R8", "count restarted by agreeing sample", hook_closed, 1'b0);
        push(sm(0, 40), '0);
        check("R8", "third consecutive closes", hook_closed, 1'b1);
        check("R10", "irq on closing", irq_pend, 1'b1);
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check("R11", "clear pulse clears", irq_pend, 1'b0);
        push(sm(0, 5), '0);
        push(sm(0, 5), '0);
        push(sm(0, 5), '0);
        check("R8", "release after three", hook_closed, 1'b0);
        check("R10", "irq on release", irq_pend, 1'b1);
    endtask

    task automatic t_debounce_zero();
        do_reset();
        thr_hi = 6'd20;
        dbc_ticks = 8'd0;
        push(sm(0, 40), '0);
        check("R8", "interval 0 acts as 1", hook_closed, 1'b1);
    endtask

    task automatic t_hyst_current();
        do_reset();
        hyst_en = 1'b1;
        thr_hi = 6'd30;
        thr_lo = 6'd10;
        push(sm(0, 25), '0);
        check("R6", "inside band from open", hook_closed, 1'b0);
        push(sm(0, 35), '0);
        check("R6", "above upper closes", hook_closed, 1'b1);
        push(sm(0, 15), '0);
        check("R6", "inside band held closed", hook_closed, 1'b1);
        push(sm(0, 10), '0);
        check("R6", "at lower releases", hook_closed, 1'b0);
    endtask

    task automatic t_voltage();
        do_reset();
        vmode = 1'b1;
        thr_hi = 6'd20;
        push(sm(0, 60), sm(1, 30));
        check("R7", "high voltage open despite current", hook_closed, 1'b0);
        push(sm(0, 0), sm(1, 15));
        check("R7", "low voltage closes", hook_closed, 1'b1);
        do_reset();
        vmode = 1'b1;
        hyst_en = 1'b1;
        thr_hi = 6'd30;
        thr_lo = 6'd10;
        push('0, sm(0, 15));
        check("R7", "hyst band from open", hook_closed, 1'b0);
        push('0, sm(0, 5));
        check("R7", "below lower closes", hook_closed, 1'b1);
        push('0, sm(0, 25));
        check("R7", "hyst band held closed", hook_closed, 1'b1);
        push('0, sm(0, 35));
        check("R7", "above upper releases", hook_closed, 1'b0);
    endtask

    task automatic t_filter();
        do_reset();
        lpf_coef = 12'd2047;
        thr_hi = 6'd30;
        feed_state = 3'b000;
        for (int i = 0; i < 4; i++) push(sm(0, 40), '0);
        feed_state = 3'b001;
        push(sm(0, 40), '0);
        check("R3", "filter did not see gated samples (y=20)", hook_closed, 1'b0);
        push(sm(0, 40), '0);
        check("R4", "second step y=30 not above 30", hook_closed, 1'b0);
        push(sm(0, 40), '0);
        check("R4", "third step y=35 closes", hook_closed, 1'b1);
    endtask

    task automatic t_irq_mask_and_race();
        do_reset();
        thr_hi = 6'd20;
        push(sm(0, 40), '0);
        check("R10", "closed with irq disabled", hook_closed, 1'b1);
        check("R10", "no irq when disabled", irq_pend, 1'b0);
        irq_en = 1'b1;
        @(negedge clk);
        cur_smp = sm(0, 2);
        smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check("R11", "set wins over same-edge clear", irq_pend, 1'b1);
        check("R11", "release took effect", hook_closed, 1'b0);
    endtask

    initial begin
        t_reset();
        t_gating_latency();
        t_threshold_edge();
        t_negative();
        t_debounce_irq();
        t_debounce_zero();
        t_hyst_current();
        t_voltage();
        t_filter();
        t_irq_mask_and_race();
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests_run++;
        tests_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
        $finish;
    end

endmodule